// File: doc/BRIEF.md
# Two-Bank Asynchronous Memory Strobe Sequencer

This block runs accesses to external asynchronous devices such as SRAM, flash or memory-mapped peripherals. It drives three active-low lines: an output-enable, a read strobe and a write strobe. There are two banks, and each bank has its own timing word. The two words sit together in one 32-bit control register. The sequencer orders each access as follows: optional idle (transition) cycles, then setup with only output-enable low, then the access with the strobe low, then hold with only output-enable low, and finally a single-cycle done indication.

A host issues a request with one-cycle `reqValid` while `busy` is low. The request carries the direction, the bank, the address and the write data. The block copies the bank's timing word at that moment, so a change to the control register affects only later accesses. A ready input can stretch the strobe. Each bank enables this separately and sets its own polarity.

Top module: `async_bank_seq`

## Requirements
- R1: After reset the control register reads 0xFFC2FFC2. Output-enable, read strobe and write strobe are all high, and `done` and `busy` are low.
- R2: Bank 0 takes its timing from bits 15:0 of the control register and bank 1 from bits 31:16. Inside each 16-bit word the fields are: write access code [15:12], read access code [11:8], hold code [7:6], setup code [5:4], transition code [3:2], ready polarity [1], ready enable [0].
- R3: Output-enable goes low before the strobe for the setup time. Setup codes 1, 2 and 3 give that many cycles, and code 0 gives 4 cycles.
- R4: The strobe stays low for the access code of the bank in the access's direction. Codes 1 to 15 give 1 to 15 cycles, and code 0 gives 1 cycle.
- R5: After the strobe rises, output-enable stays low for the hold code (0 to 3) in cycles.
- R6: Idle cycles are inserted between two accesses in two cases: a read followed by a write to the same bank, or a read followed by a read to the other bank. Their number comes from the transition code of the bank that was read. Codes 1 to 3 give that many cycles and code 0 gives 4. In every other case no idle cycles are inserted.
- R7: While a bank's ready enable is 0, the ready input has no effect on the access length.
- R8: While ready enable is 1 and the access count has run out, the strobe stays low until ready equals the polarity bit. Ready is checked once per cycle.
- R9: `memAddr` (and `memWdata` on writes) hold the request's values for the whole access. Read data is captured in the strobe's last cycle. `done` pulses for one cycle after hold, with all three memory lines high, and `rdData` holds the captured word.
- R10: A request is taken only while `busy` is low, and a request raised while `busy` is high is dropped. A control-register write made during an access does not change that access.
- R11: Read and write strobes are never low together, and a strobe is low only while output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control register write enable |
| cfgWrData | input | 32 | Control register write value |
| cfgRdData | output | 32 | Control register contents |
| reqValid | input | 1 | Request pulse, taken while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | 1 | Bank select |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Last captured read word |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data |
| memReady | input | 1 | Device ready |
| memOeN | output | 1 | Output-enable, active low |
| memReN | output | 1 | Read strobe, active low |
| memWeN | output | 1 | Write strobe, active low |

## Verification
Two situations are hard to reach from the ports. The first is the transition gap, because it depends on the history of the previous access rather than on the current request. The stimulus therefore chains accesses in deliberate orders: read then read on the same bank, read then read on the other bank, read then write on the same bank, and write then read. The second is stretching by ready. A device model counts the cycles of strobe-low time and holds ready at the wrong level until a chosen count. The same model holds ready wrong on a bank with ready disabled, which shows that the input is ignored there. A control-register write and a dropped request are both injected in the middle of an access.

// File: rtl/async_bank_pkg.sv
package async_bank_pkg;

  localparam int NUM_BANKS = 2;
  localparam int WORD_W    = 16;
  localparam int CFG_W     = NUM_BANKS * WORD_W;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'hFFC2_FFC2;

  // Field order follows the bit layout of one bank word, msb first.
  typedef struct packed {
    logic [3:0] wrAcc;
    logic [3:0] rdAcc;
    logic [1:0] hold;
    logic [1:0] setup;
    logic [1:0] trans;
    logic       rdyPol;
    logic       rdyEn;
  } bankTiming_t;

  typedef struct packed {
    logic load;     // take request and snapshot timing
    logic capture;  // latch memory read data
  } dpCmd_t;

  typedef struct packed {
    logic oeOn;
    logic reOn;
    logic weOn;
    logic done;
  } busPins_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TRANS, ST_SETUP, ST_ACCESS, ST_HOLD, ST_DONE
  } seqState_t;

  // Two-bit code where zero stands for four cycles.
  function automatic logic [3:0] wrapFour(input logic [1:0] code);
    return (code == 2'd0) ? 4'd4 : {2'b00, code};
  endfunction

  // Access code with zero clamped to one cycle.
  function automatic logic [3:0] atLeastOne(input logic [3:0] code);
    return (code == 4'd0) ? 4'd1 : code;
  endfunction

endpackage

// File: rtl/async_bank_dp.sv
module async_bank_dp
  import async_bank_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  input  logic              reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  dpCmd_t            cmd,
  output logic [1:0]        liveSetup,
  output bankTiming_t       curTiming,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdData
);

  logic [CFG_W-1:0]  cfgReg;
  logic [WORD_W-1:0] bankWord [NUM_BANKS];
  bankTiming_t       liveTiming;

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : gBank
      assign bankWord[g] = cfgReg[g*WORD_W +: WORD_W];
    end
  endgenerate

  assign liveTiming = bankTiming_t'(bankWord[reqBank]);
  assign liveSetup  = liveTiming.setup;
  assign cfgRdData  = cfgReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgReg <= CFG_RESET;
    end else if (cfgWrEn) begin
      cfgReg <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curTiming <= bankTiming_t'(CFG_RESET[WORD_W-1:0]);
      memAddr   <= '0;
      memWdata  <= '0;
    end else if (cmd.load) begin
      curTiming <= liveTiming;
      memAddr   <= reqAddr;
      memWdata  <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (cmd.capture) begin
      rdData <= memRdata;
    end
  end

endmodule

// File: rtl/async_bank_ctrl.sv
module async_bank_ctrl
  import async_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqBank,
  input  logic [1:0]  liveSetup,
  input  bankTiming_t curTiming,
  input  logic        memReady,
  output dpCmd_t      cmd,
  output busPins_t    pins,
  output logic        busy
);

  seqState_t  state;
  logic [3:0] cnt;
  logic       isWrite;
  logic       prevRead;
  logic       prevBank;
  logic [1:0] prevTrans;

  logic       accept;
  logic       needTrans;
  logic       readyOk;
  logic       accEnd;
  logic [3:0] accLen;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign needTrans = prevRead &&
                     ((reqWrite && (reqBank == prevBank)) ||
                      (!reqWrite && (reqBank != prevBank)));
  assign accLen    = isWrite ? atLeastOne(curTiming.wrAcc)
                             : atLeastOne(curTiming.rdAcc);
  assign readyOk   = !curTiming.rdyEn || (memReady == curTiming.rdyPol);
  assign accEnd    = (state == ST_ACCESS) && (cnt == 4'd0) && readyOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      isWrite   <= 1'b0;
      prevRead  <= 1'b0;
      prevBank  <= 1'b0;
      prevTrans <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            isWrite  <= reqWrite;
            prevRead <= !reqWrite;
            prevBank <= reqBank;
            if (needTrans) begin
              state <= ST_TRANS;
              cnt   <= wrapFour(prevTrans) - 4'd1;
            end else begin
              state <= ST_SETUP;
              cnt   <= wrapFour(liveSetup) - 4'd1;
            end
          end
        end
        ST_TRANS: begin
          if (cnt == 4'd0) begin
            state <= ST_SETUP;
            cnt   <= wrapFour(curTiming.setup) - 4'd1;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        ST_SETUP: begin
          if (cnt == 4'd0) begin
            state <= ST_ACCESS;
            cnt   <= accLen - 4'd1;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        ST_ACCESS: begin
          if (cnt != 4'd0) begin
            cnt <= cnt - 4'd1;
          end else if (readyOk) begin
            if (curTiming.hold == 2'd0) begin
              state <= ST_DONE;
            end else begin
              state <= ST_HOLD;
              cnt   <= {2'b00, curTiming.hold} - 4'd1;
            end
          end
        end
        ST_HOLD: begin
          if (cnt == 4'd0) state <= ST_DONE;
          else             cnt   <= cnt - 4'd1;
        end
        ST_DONE: begin
          prevTrans <= curTiming.trans;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.load     = accept;
    cmd.capture  = accEnd && !isWrite;
    pins.oeOn    = (state == ST_SETUP) || (state == ST_ACCESS) || (state == ST_HOLD);
    pins.reOn    = (state == ST_ACCESS) && !isWrite;
    pins.weOn    = (state == ST_ACCESS) && isWrite;
    pins.done    = (state == ST_DONE);
    busy         = (state != ST_IDLE);
  end

endmodule

// File: rtl/async_bank_seq.sv
module async_bank_seq
  import async_bank_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              memOeN,
  output logic              memReN,
  output logic              memWeN
);

  dpCmd_t      cmd;
  busPins_t    pins;
  bankTiming_t curTiming;
  logic [1:0]  liveSetup;

  async_bank_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqBank   (reqBank),
    .liveSetup (liveSetup),
    .curTiming (curTiming),
    .memReady  (memReady),
    .cmd       (cmd),
    .pins      (pins),
    .busy      (busy)
  );

  async_bank_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .reqBank   (reqBank),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .memRdata  (memRdata),
    .cmd       (cmd),
    .liveSetup (liveSetup),
    .curTiming (curTiming),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rdData    (rdData)
  );

  assign memOeN = !pins.oeOn;
  assign memReN = !pins.reOn;
  assign memWeN = !pins.weOn;
  assign done   = pins.done;

endmodule

// File: rtl/async_bank_seq_chk.sv
module async_bank_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              memOeN,
  input logic              memReN,
  input logic              memWeN,
  input logic              done,
  input logic              busy,
  input logic [ADDR_W-1:0] memAddr
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    memReN || memWeN);  // R11

  AST_STROBE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (!memReN || !memWeN) |-> !memOeN);  // R11

  AST_SETUP_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(memReN) || $fell(memWeN)) |-> $past(!memOeN));  // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (memOeN && memReN && memWeN && busy));  // R9

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!memOeN && $past(!memOeN)) |-> $stable(memAddr));  // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (memOeN && memReN && memWeN && !done));  // R10

endmodule

bind async_bank_seq async_bank_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .memOeN  (memOeN),
  .memReN  (memReN),
  .memWeN  (memWeN),
  .done    (done),
  .busy    (busy),
  .memAddr (memAddr)
);

// File: tb/async_bank_seq_tb.sv
module async_bank_seq_tb;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [31:0]   cfgWrData = '0;
  logic [31:0]   cfgRdData;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic          reqBank = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          busy, done;
  logic [DW-1:0] rdData;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata;
  logic          memReady = 1'b0;
  logic          memOeN, memReN, memWeN;

  always #10 clk = ~clk;  // 50 MHz

  async_bank_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy),
    .done(done), .rdData(rdData), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .memOeN(memOeN),
    .memReN(memReN), .memWeN(memWeN)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Device model: read data from address, ready held wrong until a strobe-cycle count.
  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'h5A3C;
  endfunction
  assign memRdata = memReN ? '0 : memWord(memAddr);

  int rdyAfter = 0;
  bit rdyLevel = 1'b1;
  int rdyCnt = 0;
  always @(negedge clk) begin
    if (!memReN || !memWeN) rdyCnt++;
    else rdyCnt = 0;
    memReady = (rdyCnt >= rdyAfter) ? rdyLevel : !rdyLevel;
  end

  typedef struct {
    bit wr; int trans; int setup; int acc; int hold;
    logic [AW-1:0] addr; logic [DW-1:0] wdata; string accTag;
  } exp_t;
  exp_t expQ[$];

  // Bench-side model of configuration and access history.
  logic [31:0] cfgModel = 32'hFFC2_FFC2;
  bit          prevReadM = 1'b0;
  bit          prevBankM = 1'b0;
  int          prevTransM = 0;

  task automatic setCfg(input logic [31:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    cfgModel = v;
    check(cfgRdData == v, "R2", "cfg readback", cfgRdData, v);
  endtask

  task automatic issue(input bit wr, input bit bank, input logic [AW-1:0] addr,
                       input logic [DW-1:0] wd, input int rAfter, input bit rLvl,
                       input string accTag, input bit waitEnd);
    logic [15:0] w;
    exp_t it;
    int code;
    w = bank ? cfgModel[31:16] : cfgModel[15:0];
    it.wr = wr; it.addr = addr; it.wdata = wd; it.accTag = accTag;
    it.setup = (w[5:4] == 0) ? 4 : int'(w[5:4]);
    code = wr ? int'(w[15:12]) : int'(w[11:8]);
    it.acc = (code == 0) ? 1 : code;
    if (w[0] && rAfter > it.acc) it.acc = rAfter;
    it.hold = int'(w[7:6]);
    it.trans = (prevReadM && ((wr && bank == prevBankM) || (!wr && bank != prevBankM)))
               ? ((prevTransM == 0) ? 4 : prevTransM) : 0;
    prevReadM = !wr; prevBankM = bank; prevTransM = int'(w[3:2]);
    expQ.push_back(it);
    rdyAfter = rAfter; rdyLevel = rLvl;
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBank = bank; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    if (waitEnd) while (busy) @(negedge clk);
  endtask

  // Monitor: measure phases and compare against the queue on done.
  int trC = 0, suC = 0, stC = 0, hoC = 0;
  bit seenStb = 1'b0, busBad = 1'b0;
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (done) begin
        exp_t it;
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          it = expQ.pop_front();
          check(trC == it.trans, "R6", "transition cycles", trC, it.trans);
          check(suC == it.setup, "R3", "setup cycles", suC, it.setup);
          check(stC == it.acc, it.accTag, "strobe cycles", stC, it.acc);
          check(hoC == it.hold, "R5", "hold cycles", hoC, it.hold);
          check(!busBad, "R9", "address/data held during strobe", busBad, 0);
          if (!it.wr)
            check(rdData == memWord(it.addr), "R9", "read data", rdData, memWord(it.addr));
        end
        trC = 0; suC = 0; stC = 0; hoC = 0; seenStb = 0; busBad = 0;
      end else if (memOeN) begin
        trC++;
      end else if (!memReN || !memWeN) begin
        stC++; seenStb = 1'b1;
        if (expQ.size() > 0) begin
          if (memAddr != expQ[0].addr) busBad = 1'b1;
          if (expQ[0].wr && (memWdata != expQ[0].wdata || memWeN)) busBad = 1'b1;
          if (!expQ[0].wr && memReN) busBad = 1'b1;
        end
      end else if (!seenStb) begin
        suC++;
      end else begin
        hoC++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cfgRdData == 32'hFFC2_FFC2, "R1", "cfg reset", cfgRdData, 32'hFFC2_FFC2);
    check(memOeN && memReN && memWeN, "R1", "strobes idle", {memOeN, memReN, memWeN}, 3'b111);
    check(!done && !busy, "R1", "done/busy low", {done, busy}, 2'b00);

    // Defaults: setup 4, access 15, hold 3, transition 4
    issue(0, 0, 20'h00123, '0, 0, 1, "R4", 1);
    issue(0, 0, 20'h00456, '0, 0, 1, "R4", 1);      // same-bank read: no gap (R6)
    issue(0, 1, 20'h10789, '0, 0, 1, "R2", 1);      // other bank read: gap 4 (R6)

    // bank0: wr3 rd2 hold1 setup1 trans2 pol1 en0 ; bank1: wr0 rd0 hold0 setup3 trans1 pol0 en1
    setCfg(32'h0035_325A);
    issue(1, 0, 20'h00ABC, 16'hBEEF, 0, 1, "R4", 1); // after read of bank1, write bank0: no gap
    issue(0, 0, 20'h00DEF, '0, 0, 1, "R4", 1);      // after write: no gap
    issue(1, 0, 20'h00111, 16'h1234, 0, 1, "R4", 1); // read then write same bank: gap 2
    issue(0, 1, 20'h12222, '0, 0, 0, "R4", 1);      // code 0 access -> 1, ready low immediate
    issue(0, 1, 20'h13333, '0, 4, 0, "R8", 1);      // ready stretch to 4
    issue(0, 0, 20'h04444, '0, 6, 0, "R7", 1);      // ready wrong but disabled; gap 1
    issue(1, 1, 20'h15555, 16'hCAFE, 3, 0, "R8", 1); // write stretched to 3

    // R10: config write and stray request in the middle of an access
    issue(0, 0, 20'h06666, '0, 0, 1, "R10", 0);
    setCfg(32'h0035_15AF);
    reqValid = 1'b1; reqWrite = 1'b1; reqBank = 1'b1; reqAddr = 20'h1FFFF;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!busy && memWeN, "R10", "request during busy dropped", {busy, memWeN}, 2'b01);
    issue(0, 0, 20'h07777, '0, 0, 1, "R10", 1);     // new bank0 timing now applies
    issue(0, 0, 20'h08888, '0, 7, 1, "R8", 1);      // ready high polarity, stretch to 7

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9", "all accesses completed", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule